// File: doc/BRIEF.md
# Smart Card Power Sequencer

This block owns the timed power-up and power-down of a contact smart card. It watches a host command line (active low), a mode line, a host reset request, a card-present input and three fault flags. From these it drives the enables for the supply booster, the card supply, the card I/O transceivers and the card clock, the card reset line, and an active-low interrupt back to the host. The analog circuits that build the supply and that sense the faults are outside the block. Only their enables and flags cross its boundary.

All step timing comes from one half-period tick, which is `HALF_T_CYCLES` core clocks long (call it H; a full period T is 2H). A single step counter counts these ticks upward while the card is powered up. It is reloaded and counts down during power-down, so each switching point is a fixed compare value. Power-up starts from idle when the host asserts the command while the mode line is high. If mode is low, the block sleeps and refuses to start. Power-down starts when the command is released, when mode drops, or when a fault is seen. After a fault the interrupt stays asserted until the host has released the command and a card is present. Leaving sleep takes `WAKE_CYCLES` core clocks before the block is ready again.

Top module: `card_power_seq`

## Requirements
- R1: From reset, and for as long as `supv_rdy` is low, the block stays powered off. All five card-side outputs are 0 and `off_n` is 1.
- R2: In idle with `mode`=1, `cmd_n`=0 starts power-up. With `mode`=0 the block sleeps, and `cmd_n`=0 has no effect: every card-side output stays 0.
- R3: Power-up timing, counted from the clock edge that starts it. `boost_en` rises at once. `vcc_en` rises after 3H cycles and `io_en` after 8H cycles. The powered state is reached after 14H cycles.
- R4: From 8H up to 14H, `card_clk_en` equals `host_rst`. In the powered state `card_clk_en`=1 and `card_rst` equals the inverse of `host_rst`. Before that state, `card_rst` is 0.
- R5: A normal power-down starts when `cmd_n` goes to 1 or `mode` goes to 0 in the powered state. `card_rst` drops at once, `card_clk_en` after H, `io_en` after 2H, `vcc_en` after 3H and `boost_en` after 10H. The block then goes to idle, or to sleep if `mode` is 0.
- R6: If power-up is cut short, the power-down that follows never raises an enable that power-up had not yet raised. It still keeps `boost_en` high for 10H.
- R7: During power-up or in the powered state, any of these causes a fault: `card_present`=0, `flt_ovc`=1, `flt_vdrop`=1 or `flt_temp`=1. The fault drops `off_n` at the next edge and starts the same power-down.
- R8: After a fault power-down, `off_n` returns to 1 and idle is re-entered only on an edge where both `cmd_n`=1 and `card_present`=1. Until then `off_n` stays 0 and no power-up starts.
- R9: In sleep, `mode`=1 starts a wake delay. Idle is reached `WAKE_CYCLES` cycles later. `mode`=0 during the delay returns the block to sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| supv_rdy | input | 1 | supply supervisor released |
| cmd_n | input | 1 | host session command, active low |
| mode | input | 1 | 1 = normal, 0 = low-power request |
| host_rst | input | 1 | host reset request for the card |
| card_present | input | 1 | 1 = card inserted |
| flt_ovc | input | 1 | card supply over-current flag |
| flt_vdrop | input | 1 | host supply drop flag |
| flt_temp | input | 1 | over-temperature flag |
| boost_en | output | 1 | supply booster enable |
| vcc_en | output | 1 | card supply enable |
| io_en | output | 1 | card I/O transceiver enable |
| card_clk_en | output | 1 | card clock enable |
| card_rst | output | 1 | card reset line |
| off_n | output | 1 | fault interrupt to host, active low |

## Verification
The assertions assume that `cmd_n`, `mode` and `host_rst` change only between clock edges and are stable at each sampling edge. They also assume that fault flags are meaningful only while the card is being powered. The stimulus drives every input a fixed delay after the rising edge and holds it for whole cycles. It raises faults only during power-up or in the powered state, and it keeps `card_present` high except where removal is the point of a sequence. On that basis the enable ordering (reset ⇒ clock ⇒ I/O ⇒ supply ⇒ booster), the start condition of a power-up and the release condition of the interrupt can be checked on every edge without knowing the sequence phase.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;

  localparam int STEP_W = 4;
  typedef logic [STEP_W-1:0] step_t;

  // Half-period step marks; the ordering of these is the block's behaviour.
  localparam step_t UP_VCC      = 4'd3;   // supply on during power-up
  localparam step_t UP_IO       = 4'd8;   // I/O and clock window open
  localparam step_t UP_DONE     = 4'd14;  // powered state reached
  localparam step_t DN_START    = 4'd10;  // reload value for power-down
  localparam step_t DN_IO_KEEP  = 4'd9;   // I/O kept while step >= this
  localparam step_t DN_VCC_KEEP = 4'd8;   // supply kept while step >= this

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_SLEEP = 3'd2,
    ST_WAKE  = 3'd3,
    ST_RAMP  = 3'd4,
    ST_LIVE  = 3'd5,
    ST_DRAIN = 3'd6,
    ST_HOLD  = 3'd7
  } seq_state_e;

endpackage

// File: rtl/cps_tick_gen.sv
`timescale 1ns/1ps
module cps_tick_gen #(
  parameter int HALF_T_CYCLES = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PRE_W = (HALF_T_CYCLES > 1) ? $clog2(HALF_T_CYCLES) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(HALF_T_CYCLES - 1);

  logic [PRE_W-1:0] pcnt_q, pcnt_d;

  assign tick = (pcnt_q == LAST);

  always_comb begin
    if (restart || tick) pcnt_d = '0;
    else                 pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/cps_fsm.sv
`timescale 1ns/1ps
module cps_fsm
  import cps_pkg::*;
#(
  parameter int WAKE_CYCLES = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       supv_rdy,
  input  logic       cmd_n,
  input  logic       mode,
  input  logic       card_present,
  input  logic       flt_ovc,
  input  logic       flt_vdrop,
  input  logic       flt_temp,
  output seq_state_e state,
  output step_t      step,
  output step_t      lvl,
  output logic       fault_q,
  output logic       restart
);
  localparam int WAKE_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [WAKE_W-1:0] WAKE_LAST = WAKE_W'(WAKE_CYCLES - 1);

  seq_state_e        st_q, st_d;
  step_t             step_q, step_d;
  step_t             lvl_q, lvl_d;
  logic              flt_q, flt_d;
  logic [WAKE_W-1:0] wcnt_q, wcnt_d;

  logic fault_now, abort;
  assign fault_now = !card_present || flt_ovc || flt_vdrop || flt_temp;
  assign abort     = fault_now || cmd_n || !mode;

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    lvl_d  = lvl_q;
    flt_d  = flt_q;
    wcnt_d = wcnt_q;
    unique case (st_q)
      ST_OFF: begin
        if (supv_rdy) st_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (!mode) begin
          st_d = ST_SLEEP;
        end else if (!cmd_n) begin
          st_d   = ST_RAMP;
          step_d = '0;
        end
      end
      ST_SLEEP: begin
        if (mode) begin
          st_d   = ST_WAKE;
          wcnt_d = '0;
        end
      end
      ST_WAKE: begin
        if (!mode)                  st_d = ST_SLEEP;
        else if (wcnt_q == WAKE_LAST) st_d = ST_IDLE;
        else                        wcnt_d = wcnt_q + 1'b1;
      end
      ST_RAMP: begin
        if (abort) begin
          st_d   = ST_DRAIN;
          lvl_d  = step_q;
          step_d = DN_START;
          flt_d  = fault_now;
        end else if (tick) begin
          if (step_q == UP_DONE - 4'd1) st_d = ST_LIVE;
          else                          step_d = step_q + 4'd1;
        end
      end
      ST_LIVE: begin
        if (abort) begin
          st_d   = ST_DRAIN;
          lvl_d  = UP_DONE;
          step_d = DN_START;
          flt_d  = fault_now;
        end
      end
      ST_DRAIN: begin
        if (tick) begin
          if (step_q == 4'd1) begin
            step_d = '0;
            if (flt_q)      st_d = ST_HOLD;
            else if (!mode) st_d = ST_SLEEP;
            else            st_d = ST_IDLE;
          end else begin
            step_d = step_q - 4'd1;
          end
        end
      end
      ST_HOLD: begin
        if (cmd_n && card_present) begin
          st_d  = ST_IDLE;
          flt_d = 1'b0;
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      step_q <= '0;
      lvl_q  <= '0;
      flt_q  <= 1'b0;
      wcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      lvl_q  <= lvl_d;
      flt_q  <= flt_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign state   = st_q;
  assign step    = step_q;
  assign lvl     = lvl_q;
  assign fault_q = flt_q;
  assign restart = (st_d != st_q);
endmodule

// File: rtl/cps_out_decode.sv
`timescale 1ns/1ps
module cps_out_decode
  import cps_pkg::*;
(
  input  seq_state_e state,
  input  step_t      step,
  input  step_t      lvl,
  input  logic       host_rst,
  output logic       boost_en,
  output logic       vcc_en,
  output logic       io_en,
  output logic       card_clk_en,
  output logic       card_rst
);
  logic ramp, live, drain;

  always_comb begin
    ramp  = (state == ST_RAMP);
    live  = (state == ST_LIVE);
    drain = (state == ST_DRAIN);

    boost_en = ramp || live || drain;

    vcc_en = (ramp && step >= UP_VCC) || live ||
             (drain && step >= DN_VCC_KEEP && lvl >= UP_VCC);

    io_en  = (ramp && step >= UP_IO) || live ||
             (drain && step >= DN_IO_KEEP && lvl >= UP_IO);

    card_clk_en = (ramp && step >= UP_IO && host_rst) || live ||
                  (drain && step == DN_START && lvl >= UP_IO &&
                   (lvl >= UP_DONE || host_rst));

    card_rst = live && !host_rst;
  end
endmodule

// File: rtl/card_power_seq.sv
`timescale 1ns/1ps
module card_power_seq
  import cps_pkg::*;
#(
  parameter int HALF_T_CYCLES = 625,
  parameter int WAKE_CYCLES   = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supv_rdy,
  input  logic cmd_n,
  input  logic mode,
  input  logic host_rst,
  input  logic card_present,
  input  logic flt_ovc,
  input  logic flt_vdrop,
  input  logic flt_temp,
  output logic boost_en,
  output logic vcc_en,
  output logic io_en,
  output logic card_clk_en,
  output logic card_rst,
  output logic off_n
);
  seq_state_e state;
  step_t      step, lvl;
  logic       tick, restart, fault_q;

  cps_tick_gen #(.HALF_T_CYCLES(HALF_T_CYCLES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick)
  );

  cps_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .supv_rdy     (supv_rdy),
    .cmd_n        (cmd_n),
    .mode         (mode),
    .card_present (card_present),
    .flt_ovc      (flt_ovc),
    .flt_vdrop    (flt_vdrop),
    .flt_temp     (flt_temp),
    .state        (state),
    .step         (step),
    .lvl          (lvl),
    .fault_q      (fault_q),
    .restart      (restart)
  );

  cps_out_decode u_dec (
    .state       (state),
    .step        (step),
    .lvl         (lvl),
    .host_rst    (host_rst),
    .boost_en    (boost_en),
    .vcc_en      (vcc_en),
    .io_en       (io_en),
    .card_clk_en (card_clk_en),
    .card_rst    (card_rst)
  );

  assign off_n = !fault_q;
endmodule

// File: rtl/cps_checker.sv
`timescale 1ns/1ps
module cps_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_n,
  input logic mode,
  input logic card_present,
  input logic boost_en,
  input logic vcc_en,
  input logic io_en,
  input logic card_clk_en,
  input logic card_rst
  , input logic off_n
);
  assert_supply_needs_boost_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_en |-> boost_en);

  assert_io_needs_supply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en);

  assert_clock_needs_io_R4: assert property (@(posedge clk) disable iff (!rst_n)
    card_clk_en |-> io_en);

  assert_reset_needs_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> card_clk_en);

  assert_start_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boost_en) |-> ($past(mode) && !$past(cmd_n)));

  assert_irq_only_when_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(off_n) |-> boost_en);

  assert_irq_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_n) |-> ($past(cmd_n) && $past(card_present) && !boost_en));
endmodule

bind card_power_seq cps_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_n        (cmd_n),
  .mode         (mode),
  .card_present (card_present),
  .boost_en     (boost_en),
  .vcc_en       (vcc_en),
  .io_en        (io_en),
  .card_clk_en  (card_clk_en),
  .card_rst     (card_rst),
  .off_n        (off_n)
);

// File: tb/card_power_seq_tb_top.sv
`timescale 1ns/1ps
module card_power_seq_tb_top;
  localparam int H  = 4;
  localparam int WK = 12;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n, supv_rdy, cmd_n, mode, host_rst, card_present;
  logic flt_ovc, flt_vdrop, flt_temp;
  logic boost_en, vcc_en, io_en, card_clk_en, card_rst, off_n;

  always #10 clk = ~clk;

  card_power_seq #(.HALF_T_CYCLES(H), .WAKE_CYCLES(WK)) dut_i (
    .clk(clk), .rst_n(rst_n), .supv_rdy(supv_rdy), .cmd_n(cmd_n), .mode(mode),
    .host_rst(host_rst), .card_present(card_present), .flt_ovc(flt_ovc),
    .flt_vdrop(flt_vdrop), .flt_temp(flt_temp), .boost_en(boost_en),
    .vcc_en(vcc_en), .io_en(io_en), .card_clk_en(card_clk_en),
    .card_rst(card_rst), .off_n(off_n)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  // Reference model: 0 off, 1 idle, 2 sleep, 3 wake, 4 up, 5 on, 6 down, 7 fault hold
  int ms = 0;
  int el = 0;
  int lv = 0;
  bit mflt = 1'b0;

  always @(posedge clk) begin
    int nx;
    bit fault, abort;
    cycles++;
    if (!rst_n) begin
      ms = 0; el = 0; lv = 0; mflt = 1'b0;
    end else begin
      fault = !card_present || flt_ovc || flt_vdrop || flt_temp;
      abort = fault || cmd_n || !mode;
      nx = ms;
      case (ms)
        0: if (supv_rdy) nx = 1;
        1: if (!mode) nx = 2; else if (!cmd_n) nx = 4;
        2: if (mode) nx = 3;
        3: if (!mode) nx = 2; else if (el + 1 == WK) nx = 1;
        4: if (abort) begin nx = 6; lv = el / H; mflt = fault; end
           else if (el + 1 == 14 * H) nx = 5;
        5: if (abort) begin nx = 6; lv = 14; mflt = fault; end
        6: if (el + 1 == 10 * H) nx = mflt ? 7 : (!mode ? 2 : 1);
        7: if (cmd_n && card_present) begin nx = 1; mflt = 1'b0; end
        default: nx = 0;
      endcase
      if (nx != ms) begin ms = nx; el = 0; end
      else el = el + 1;
    end
  end

  function automatic string tag_of(int s, bit f, int l);
    case (s)
      0:       return "R1";
      1, 2:    return "R2";
      3:       return "R9";
      4:       return "R3";
      5:       return "R4";
      6:       return f ? "R7" : ((l < 14) ? "R6" : "R5");
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, string nm, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, nm, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    logic e_b, e_v, e_i, e_c, e_r;
    int d;
    string t, tc;
    d = el / H;
    e_b = 0; e_v = 0; e_i = 0; e_c = 0; e_r = 0;
    case (ms)
      4: begin
        e_b = 1; e_v = (d >= 3); e_i = (d >= 8); e_c = (d >= 8) && host_rst;
      end
      5: begin
        e_b = 1; e_v = 1; e_i = 1; e_c = 1; e_r = !host_rst;
      end
      6: begin
        e_b = 1;
        e_v = (d < 3) && (lv >= 3);
        e_i = (d < 2) && (lv >= 8);
        e_c = (d < 1) && (lv >= 8) && ((lv >= 14) || host_rst);
      end
      default: ;
    endcase
    t  = tag_of(ms, mflt, lv);
    tc = (ms == 4) ? "R4" : t;   // clock gating during power-up belongs to R4
    chk(t,  "boost_en",    boost_en,    e_b);
    chk(t,  "vcc_en",      vcc_en,      e_v);
    chk(t,  "io_en",       io_en,       e_i);
    chk(tc, "card_clk_en", card_clk_en, e_c);
    chk(tc, "card_rst",    card_rst,    e_r);
    chk((ms == 7 || mflt) ? "R8" : t, "off_n", off_n, !mflt);
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL R1 watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #5;
    end
  endtask

  initial begin
    rst_n = 0; supv_rdy = 0; cmd_n = 1; mode = 1; host_rst = 0; card_present = 1;
    flt_ovc = 0; flt_vdrop = 0; flt_temp = 0;
    step(3);
    rst_n = 1;
    step(5);                         // R1: supervisor still holding
    supv_rdy = 1;
    step(3);

    // R3/R4/R5: full power-up, host reset gating, normal power-down
    cmd_n = 0;
    step(9 * H);
    host_rst = 1; step(2 * H);
    host_rst = 0; step(H);
    host_rst = 1; step(4 * H);
    host_rst = 0; step(3);
    host_rst = 1; step(3);
    cmd_n = 1;
    step(12 * H);

    // R2/R9: sleep blocks start, wake abort, wake delay, mode-low power-down
    mode = 0; step(4);
    cmd_n = 0; step(10);
    mode = 1; step(5);
    mode = 0; step(3);
    mode = 1; step(WK + 2);
    step(15 * H);
    mode = 0; step(12 * H);
    mode = 1; cmd_n = 1; step(WK + 3);

    // R6: power-up cut short early, then after the clock window opened
    cmd_n = 0; step(5 * H + 1);
    cmd_n = 1; step(12 * H);
    cmd_n = 0; step(9 * H + 2);
    cmd_n = 1; step(12 * H);
    host_rst = 0;
    cmd_n = 0; step(10 * H);
    cmd_n = 1; step(12 * H);

    // R7/R8: over-current when powered, release needs card present
    cmd_n = 0; step(15 * H);
    flt_ovc = 1; step(1);
    flt_ovc = 0; step(12 * H);
    card_present = 0; cmd_n = 1; step(6);
    card_present = 1; step(4);

    // R7/R8: card removed during power-up
    cmd_n = 0; step(6 * H);
    card_present = 0; step(12 * H);
    cmd_n = 1; step(4);
    card_present = 1; step(4);

    // R7: over-temperature when powered, supply drop during power-up
    cmd_n = 0; step(15 * H);
    flt_temp = 1; step(12 * H);
    flt_temp = 0; cmd_n = 1; step(4);
    cmd_n = 0; step(2 * H);
    flt_vdrop = 1; step(2);
    flt_vdrop = 0; step(12 * H);
    cmd_n = 1; step(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule